// File: doc/BRIEF.md
# Procedural texture coordinate combiner

This block turns a pair of texture coordinates (u, v) into one 8-bit index that addresses a colour lookup table and one that addresses an alpha lookup table. Each coordinate is unsigned 1.11 fixed point: a raw value of 2048 stands for 1.0 and the full 12-bit range covers [0, 2). Each axis first gets an optional half-unit shift that depends on the row parity of the other axis. It is then folded into [0, 1.0] by a per-axis clamp function. The two clamped values are reduced to a scalar by one of ten combining functions, and the result is scaled to the index range.

Colour and alpha each have their own combiner select. A separate-alpha flag decides whether alpha uses its own select or reuses the colour result. One of the functions needs a square root of u²+v². The block computes it with a digit-serial iteration, one result bit per cycle. A valid/ready handshake on each side covers this latency. The block holds one job at a time, and all settings are captured when the job is accepted.

Top module: `proctex_coord_comb`

## Requirements
- R1: After reset in_ready is 1 and out_valid is 0. in_ready is 1 only while no job is held, and a job is taken on a rising edge where in_valid and in_ready are both 1. The outputs stay valid and unchanged until a rising edge where out_ready is 1, and in_ready returns after that edge.
- R2: The clamp modes are selected by a 3-bit code per axis (clamp_u, clamp_v). Code 0 gives 0 when the coordinate exceeds 2048 and passes it through otherwise. Code 1 limits it to 2048, and codes 5, 6 and 7 act as code 1.
- R3: Clamp code 2 keeps only the fractional part, x mod 2048. Code 3 mirrors: x when x < 2048, otherwise 4096 − x. Code 4 is a pulse: 2048 when 1024 < x ≤ 2048, otherwise 0.
- R4: Shift code 1 on an axis adds 1024 (modulo 4096) to that coordinate when the other raw coordinate is ≥ 2048. Code 2 adds it when the other is < 2048. Codes 0 and 3 leave it unchanged. The shift acts on the raw values, before the clamp.
- R5: Combiner codes 0 to 3 give u, floor(u·u/2048), v and floor(v·v/2048), where u and v are the clamped values.
- R6: Combiner code 4 gives floor((u+v)/2). Code 5 gives floor((floor(u·u/2048) + floor(v·v/2048))/2).
- R7: Combiner code 6 gives floor(sqrt(u·u + v·v)), the exact integer root.
- R8: Combiner code 7 gives min(u, v) and code 8 gives max(u, v). Code 9 gives floor((max(u, v) + root)/2), where root is the value from R7. Codes 10 to 15 act as code 0.
- R9: A combined value r maps to an index of 255 when r ≥ 2048, and to floor(r/8) otherwise.
- R10: When sep_alpha is 0, alpha_idx equals color_idx. When sep_alpha is 1, alpha_idx comes from comb_alpha.
- R11: All coordinate and control inputs are sampled on the accepting edge. Changing them while a job is held does not alter that job's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Job offered |
| in_ready | output | 1 | Block can take a job |
| u_in | input | 12 | u coordinate, unsigned 1.11 |
| v_in | input | 12 | v coordinate, unsigned 1.11 |
| clamp_u | input | 3 | Clamp mode for u |
| clamp_v | input | 3 | Clamp mode for v |
| shift_u | input | 2 | Row shift mode for u |
| shift_v | input | 2 | Row shift mode for v |
| comb_color | input | 4 | Combiner select for colour |
| comb_alpha | input | 4 | Combiner select for alpha |
| sep_alpha | input | 1 | 1: alpha uses comb_alpha; 0: alpha reuses colour |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| color_idx | output | 8 | Colour lookup index |
| alpha_idx | output | 8 | Alpha lookup index |

## Verification
Random coordinates over the full 12-bit range are run with random clamp, shift and combiner codes. Codes outside each defined set are included, so the fallback behaviour is separated from the main modes. Directed cases sit on the thresholds at 1024, 2048 and 4095. These show whether each comparison is strict or inclusive and whether the index saturates at exactly 1.0. A root case with u = v = 2048 exercises the widest remainder of the iteration. Separate select codes for colour and alpha are given together with both values of the alpha flag, which shows whether the flag actually redirects alpha. The inputs are scrambled while a job is held and the output is stalled, which tests input capture and output hold.

// File: rtl/proctex_coord_comb.sv
module proctex_coord_comb #(
  parameter int CW = 12,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] u_in,
  input  logic [CW-1:0] v_in,
  input  logic [2:0]    clamp_u,
  input  logic [2:0]    clamp_v,
  input  logic [1:0]    shift_u,
  input  logic [1:0]    shift_v,
  input  logic [3:0]    comb_color,
  input  logic [3:0]    comb_alpha,
  input  logic          sep_alpha,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] color_idx,
  output logic [IW-1:0] alpha_idx
);
  localparam int FB   = CW - 1;
  localparam int SW   = 2 * CW;
  localparam int RW   = CW + 6;
  localparam int STEPS = CW;
  localparam int NW   = $clog2(STEPS);
  localparam logic [CW-1:0] ONE  = CW'(1) << FB;
  localparam logic [CW-1:0] HALF = CW'(1) << (FB - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ROOT, ST_DONE} state_t;
  state_t state;

  logic [CW-1:0] cu, cv;
  logic [CW-1:0] root;
  logic [SW-1:0] rad;
  logic signed [RW-1:0] rem;
  logic [NW-1:0] cnt;
  logic [3:0] sel_c, sel_a;

  function automatic logic [CW-1:0] shift_f(input logic [CW-1:0] x, input logic [1:0] m,
                                            input logic [CW-1:0] other);
    logic odd;
    odd = other[FB];
    if ((m == 2'd1 && odd) || (m == 2'd2 && !odd)) return x + HALF;
    return x;
  endfunction

  function automatic logic [CW-1:0] clamp_f(input logic [CW-1:0] x, input logic [2:0] m);
    case (m)
      3'd0: return (x > ONE) ? '0 : x;
      3'd2: return {1'b0, x[FB-1:0]};
      3'd3: return x[FB] ? CW'((CW+1)'(1) << CW) - x : x;
      3'd4: return (x > HALF && x <= ONE) ? ONE : '0;
      default: return (x > ONE) ? ONE : x;
    endcase
  endfunction

  function automatic logic [CW-1:0] sq_f(input logic [CW-1:0] x);
    logic [SW-1:0] p;
    p = SW'(x) * SW'(x);
    return CW'(p >> FB);
  endfunction

  function automatic logic [CW:0] comb_f(input logic [3:0] c, input logic [CW-1:0] a,
                                         input logic [CW-1:0] b, input logic [CW-1:0] r);
    logic [CW:0] mx;
    mx = (a > b) ? {1'b0, a} : {1'b0, b};
    case (c)
      4'd1: return {1'b0, sq_f(a)};
      4'd2: return {1'b0, b};
      4'd3: return {1'b0, sq_f(b)};
      4'd4: return ({1'b0, a} + {1'b0, b}) >> 1;
      4'd5: return ({1'b0, sq_f(a)} + {1'b0, sq_f(b)}) >> 1;
      4'd6: return {1'b0, r};
      4'd7: return (a < b) ? {1'b0, a} : {1'b0, b};
      4'd8: return mx;
      4'd9: return (mx + {1'b0, r}) >> 1;
      default: return {1'b0, a};
    endcase
  endfunction

  function automatic logic [IW-1:0] idx_f(input logic [CW:0] r);
    if (r >= {1'b0, ONE}) return '1;
    return IW'(r >> (FB - IW));
  endfunction

  logic [CW-1:0] su, sv, ku, kv;
  assign su = shift_f(u_in, shift_u, v_in);
  assign sv = shift_f(v_in, shift_v, u_in);
  assign ku = clamp_f(su, clamp_u);
  assign kv = clamp_f(sv, clamp_v);

  logic [1:0] pair;
  logic signed [RW-1:0] rsh, rnext;
  assign pair  = rad[{cnt, 1'b0} +: 2];
  assign rsh   = {rem[RW-3:0], pair};
  assign rnext = rem[RW-1] ? rsh + RW'({root, 2'b11}) : rsh - RW'({root, 2'b01});

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cu    <= '0;
      cv    <= '0;
      rad   <= '0;
      rem   <= '0;
      root  <= '0;
      cnt   <= '0;
      sel_c <= '0;
      sel_a <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          cu    <= ku;
          cv    <= kv;
          rad   <= SW'(ku) * SW'(ku) + SW'(kv) * SW'(kv);
          rem   <= '0;
          root  <= '0;
          cnt   <= NW'(STEPS - 1);
          sel_c <= comb_color;
          sel_a <= sep_alpha ? comb_alpha : comb_color;
          state <= ST_ROOT;
        end
        ST_ROOT: begin
          rem  <= rnext;
          root <= {root[CW-2:0], ~rnext[RW-1]};
          cnt  <= cnt - 1'b1;
          if (cnt == '0) state <= ST_DONE;
        end
        default: if (out_ready) state <= ST_IDLE;
      endcase
    end
  end

  assign color_idx = idx_f(comb_f(sel_c, cu, cv, root));
  assign alpha_idx = idx_f(comb_f(sel_a, cu, cv, root));
endmodule

module proctex_coord_comb_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] color_idx,
  input logic [IW-1:0] alpha_idx
);
  p_hold_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(color_idx) && $stable(alpha_idx));
  p_one_job_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid);
  p_drain_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);
endmodule

bind proctex_coord_comb proctex_coord_comb_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .color_idx(color_idx), .alpha_idx(alpha_idx)
);

// File: tb/proctex_coord_comb_tb.sv
`timescale 1ns/1ps
module proctex_coord_comb_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, sep_alpha = 0;
  logic in_ready, out_valid;
  logic [11:0] u_in = 0, v_in = 0;
  logic [2:0] clamp_u = 0, clamp_v = 0;
  logic [1:0] shift_u = 0, shift_v = 0;
  logic [3:0] comb_color = 0, comb_alpha = 0;
  logic [7:0] color_idx, alpha_idx;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  proctex_coord_comb u_dut (.*);

  function automatic int bshift(int x, int m, int other);
    if ((m == 1 && other >= 2048) || (m == 2 && other < 2048)) return (x + 1024) % 4096;
    return x;
  endfunction

  function automatic int bclamp(int x, int m);
    case (m)
      0: return (x > 2048) ? 0 : x;
      2: return x % 2048;
      3: return (x < 2048) ? x : 4096 - x;
      4: return (x > 1024 && x <= 2048) ? 2048 : 0;
      default: return (x > 2048) ? 2048 : x;
    endcase
  endfunction

  function automatic int bsqrt(int s);
    int q = 0;
    while ((q + 1) * (q + 1) <= s) q++;
    return q;
  endfunction

  function automatic int bcomb(int c, int a, int b);
    int mx = (a > b) ? a : b;
    int rt = bsqrt(a * a + b * b);
    case (c)
      1: return (a * a) / 2048;
      2: return b;
      3: return (b * b) / 2048;
      4: return (a + b) / 2;
      5: return ((a * a) / 2048 + (b * b) / 2048) / 2;
      6: return rt;
      7: return (a < b) ? a : b;
      8: return mx;
      9: return (mx + rt) / 2;
      default: return a;
    endcase
  endfunction

  function automatic int bidx(int r);
    return (r >= 2048) ? 255 : r / 8;
  endfunction

  function automatic string ctag(int c);
    if (c <= 3 || c >= 10) return "R5";
    if (c <= 5) return "R6";
    if (c == 6) return "R7";
    return "R8";
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_job(int u, int v, int cu, int cv, int su, int sv,
                         int cc, int ca, int sep, string tag);
    int a, b, ec, ea, stall;
    logic [7:0] hc, ha;
    a  = bclamp(bshift(u, su, v), cu);
    b  = bclamp(bshift(v, sv, u), cv);
    ec = bidx(bcomb(cc, a, b));
    ea = sep ? bidx(bcomb(ca, a, b)) : ec;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    u_in = 12'(u); v_in = 12'(v); clamp_u = 3'(cu); clamp_v = 3'(cv);
    shift_u = 2'(su); shift_v = 2'(sv); comb_color = 4'(cc); comb_alpha = 4'(ca);
    sep_alpha = 1'(sep); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    // R11: scramble inputs while the job is held
    u_in = 12'($urandom); v_in = 12'($urandom); clamp_u = 3'($urandom);
    clamp_v = 3'($urandom); comb_color = 4'($urandom); comb_alpha = 4'($urandom);
    sep_alpha = 1'($urandom); shift_u = 2'($urandom); shift_v = 2'($urandom);
    while (!out_valid) @(negedge clk);
    hc = color_idx; ha = alpha_idx;
    stall = $urandom % 3;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check("R1 hold", {out_valid, color_idx, alpha_idx}, {1'b1, hc, ha});
    end
    check({tag, " colour ", ctag(cc)}, color_idx, ec);
    check({tag, sep ? " alpha R10 " : " alpha-reuse R10 ", ctag(ca)}, alpha_idx, ea);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check("R1 ready after drain", {in_ready, out_valid}, 2'b10);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    check("R1 reset", {in_ready, out_valid}, 2'b10);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {in_ready, out_valid}, 2'b10);
    // R2 thresholds
    run_job(2048, 2049, 0, 0, 0, 0, 0, 2, 1, "R2 zero");
    run_job(4095, 100, 1, 6, 0, 0, 0, 2, 1, "R2 edge");
    // R3 modes
    run_job(3000, 2048, 2, 3, 0, 0, 0, 2, 1, "R3 wrap/mirror");
    run_job(1024, 1025, 4, 4, 0, 0, 0, 2, 1, "R3 pulse");
    run_job(2048, 2049, 4, 3, 0, 0, 0, 2, 1, "R3 pulse/mirror top");
    // R4 shifts
    run_job(500, 2100, 1, 1, 1, 2, 0, 2, 1, "R4 odd/even");
    run_job(3500, 100, 2, 1, 2, 1, 0, 2, 1, "R4 wrap");
    run_job(500, 600, 1, 1, 3, 0, 0, 2, 1, "R4 none");
    // R7 widest root, R8 mean, R9 saturation
    run_job(2048, 2048, 1, 1, 0, 0, 6, 9, 1, "R7 R9 max");
    run_job(1500, 700, 1, 1, 0, 0, 9, 6, 1, "R8 R7");
    run_job(2047, 2040, 1, 1, 0, 0, 0, 2, 1, "R9 below one");
    // R10 reuse
    run_job(300, 1900, 1, 1, 0, 0, 8, 7, 0, "R10 reuse");
    run_job(300, 1900, 1, 1, 0, 0, 8, 7, 1, "R10 separate");
    for (int c = 0; c < 16; c++)
      run_job(1234, 777, 1, 1, 0, 0, c, 15 - c, 1, "combiner sweep");
    for (int i = 0; i < 300; i++)
      run_job($urandom % 4096, $urandom % 4096, $urandom % 8, $urandom % 8,
              $urandom % 4, $urandom % 4, $urandom % 16, $urandom % 16,
              $urandom % 2, "random");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule